// File: doc/BRIEF.md
# System Clock Divider Bank with Aligned Ratio Update

This block turns one source clock into several slower system clock rates. Each output is a one-cycle clock-enable pulse in the source domain. Each divider has a register that holds its divide ratio and an enable. Software writes a new ratio into that register, which only stages it. The block records which dividers were given a different ratio in a change-flag register.

The staged ratios take effect only when software issues a GO command. A GO lets every running divider finish the period it is in. It then loads the flagged ratios, clears the flags and restarts all divider counters on the same source-clock edge, so the outputs start out phase-aligned. A busy bit in the status register stays at 1 for the whole operation. Software polls it before staging new ratios or issuing another GO.

The register port is plain: a write strobe, an address and write data. Read data is a combinational function of the address. The address map is: divider i at address i (0 to N_DIV-1), command at N_DIV, status at N_DIV+1, change flags at N_DIV+2. Any other address reads 0.

Top module: `cdiv_bank`

## Requirements
- R1: A divider register keeps the divide ratio minus one in bits [RATIO_W-1:0] and its enable in bit 15 (bit DATA_W-1). It reads back what was last accepted. All other bits read 0, and after reset the whole register reads 0.
- R2: While a divider is enabled with active ratio r, its output is high for one cycle in every r+1 cycles. While it is disabled, its output stays low.
- R3: A write that changes a divider's staged ratio sets bit i of the change-flag register (address N_DIV+2). A write that carries the same ratio leaves that bit as it was.
- R4: Writing 1 to bit 0 of the command register (address N_DIV) while idle starts a GO. Bit 0 of the status register (address N_DIV+1) reads 1 from the cycle after that write until the GO completes.
- R5: Writes to divider registers while status bit 0 is 1 are ignored.
- R6: A GO command written while a GO is in progress is ignored. It neither starts a second GO nor keeps the status bit set after completion.
- R7: A staged ratio does not change the output period before a GO completes. After completion, every flagged divider runs at its staged ratio.
- R8: On completion all counters restart from zero on one edge. Counting the first cycle with status 0 as k=0, each enabled divider with ratio r pulses exactly when k mod (r+1) = r.
- R9: Completing a GO clears every change flag.
- R10: During a GO every enabled divider finishes its current full period, with pulses spaced by its old period. It then stays low until the aligned restart.
- R11: Disabled dividers are left out of the wait. With all dividers disabled, status reads 1 for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Read data for reg_addr (combinational) |
| clk_en_o | output | N_DIV | Divided clock-enable pulses, one per divider |

## Verification
A register write takes effect on the edge where reg_we is sampled. Read data follows the address in the same cycle, so the bench reads status and flags at the falling edge right after a write. Status rises one edge after the GO write and falls on the same edge that restarts the counters. The bench therefore takes the first falling edge with status 0 as cycle 0 of the new schedule and predicts each output from the ratio alone. While a GO drains, the bench checks that pulses stay on the old period. Randomized ratio and enable sets are then compared against the same schedule function.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  // bit of the command register that requests an aligned update
  localparam int unsigned CDIV_GO_BIT   = 0;
  // bit of the status register that shows an update in progress
  localparam int unsigned CDIV_BUSY_BIT = 0;

  typedef enum logic {
    GO_IDLE  = 1'b0,
    GO_DRAIN = 1'b1
  } go_state_e;
endpackage

// File: rtl/cdiv_regs.sv
module cdiv_regs
  import cdiv_pkg::*;
#(
  parameter int unsigned N_DIV   = 4,
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned ADDR_W  = 3
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [ADDR_W-1:0]               addr,
  input  logic [DATA_W-1:0]               wdata,
  input  logic                            busy,
  input  logic                            commit,
  output logic [N_DIV-1:0][RATIO_W-1:0]   staged_o,
  output logic [N_DIV-1:0]                en_o,
  output logic [N_DIV-1:0]                chg_o,
  output logic                            go_req_o,
  output logic [DATA_W-1:0]               rdata
);
  localparam int unsigned EN_BIT = DATA_W - 1;
  localparam logic [ADDR_W-1:0] CMD_A  = ADDR_W'(N_DIV);
  localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(N_DIV + 1);
  localparam logic [ADDR_W-1:0] CHG_A  = ADDR_W'(N_DIV + 2);

  logic [N_DIV-1:0][RATIO_W-1:0] staged_q;
  logic [N_DIV-1:0]              en_q;
  logic [N_DIV-1:0]              chg_q;
  logic                          unused_wdata;

  assign unused_wdata = ^wdata[EN_BIT-1:RATIO_W];
  assign go_req_o = we && (addr == CMD_A) && wdata[CDIV_GO_BIT];

  for (genvar i = 0; i < N_DIV; i++) begin : g_slot
    logic hit;
    assign hit = we && !busy && (addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        staged_q[i] <= '0;
        en_q[i]     <= 1'b0;
      end else if (hit) begin
        staged_q[i] <= wdata[RATIO_W-1:0];
        en_q[i]     <= wdata[EN_BIT];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chg_q[i] <= 1'b0;
      end else if (commit) begin
        chg_q[i] <= 1'b0;
      end else if (hit && (wdata[RATIO_W-1:0] != staged_q[i])) begin
        chg_q[i] <= 1'b1;
      end
    end

    assert_flag_on_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !busy && (addr == ADDR_W'(i)) && (wdata[RATIO_W-1:0] != staged_q[i]))
      |=> chg_q[i]);
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < N_DIV; i++) begin
      if (addr == ADDR_W'(i)) begin
        rdata[RATIO_W-1:0] = staged_q[i];
        rdata[EN_BIT]      = en_q[i];
      end
    end
    if (addr == STAT_A) rdata[CDIV_BUSY_BIT] = busy;
    if (addr == CHG_A)  rdata[N_DIV-1:0]     = chg_q;
  end

  assign staged_o = staged_q;
  assign en_o     = en_q;
  assign chg_o    = chg_q;

  assert_stage_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(staged_q) && $stable(en_q)));

  assert_flags_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (chg_q == '0));
endmodule

// File: rtl/cdiv_go_ctrl.sv
module cdiv_go_ctrl
  import cdiv_pkg::*;
#(
  parameter int unsigned N_DIV = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_req,
  input  logic [N_DIV-1:0] div_en,
  input  logic [N_DIV-1:0] parked,
  output logic             busy,
  output logic             commit
);
  go_state_e state_q, state_d;
  logic      all_done;

  // a disabled divider never holds up the realignment
  assign all_done = &(parked | ~div_en);
  assign busy     = (state_q == GO_DRAIN);
  assign commit   = busy && all_done;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GO_IDLE:  if (go_req)   state_d = GO_DRAIN;
      GO_DRAIN: if (all_done) state_d = GO_IDLE;
      default:                state_d = GO_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= GO_IDLE;
    else        state_q <= state_d;
  end

  assert_go_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && go_req) |=> busy);

  assert_go_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);

  assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_req) |=> !busy);
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int unsigned RATIO_W = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic [RATIO_W-1:0] staged,
  input  logic               chg,
  input  logic               busy,
  input  logic               commit,
  output logic               pulse_o,
  output logic               parked_o
);
  logic [RATIO_W-1:0] active_q;
  logic [RATIO_W-1:0] cnt_q;
  logic               park_q;
  logic               term;

  assign term     = (cnt_q == active_q);
  assign pulse_o  = en && !park_q && term;
  assign parked_o = park_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
      cnt_q    <= '0;
      park_q   <= 1'b0;
    end else if (commit) begin
      cnt_q  <= '0;
      park_q <= 1'b0;
      if (chg) active_q <= staged;
    end else if (!en) begin
      cnt_q  <= '0;
      park_q <= 1'b0;
    end else if (park_q) begin
      cnt_q <= '0;
    end else if (term) begin
      cnt_q <= '0;
      if (busy) park_q <= 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assert_one_cycle_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_o && (active_q != '0) && !commit) |=> !pulse_o);

  assert_park_after_full_period_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(park_q) |-> $past(pulse_o));

  assert_aligned_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> (cnt_q == '0 && !park_q));
endmodule

// File: rtl/cdiv_bank.sv
module cdiv_bank
  import cdiv_pkg::*;
#(
  parameter int unsigned N_DIV   = 4,
  parameter int unsigned RATIO_W = 5,
  parameter int unsigned DATA_W  = 16,
  localparam int unsigned ADDR_W = $clog2(N_DIV + 3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [N_DIV-1:0]  clk_en_o
);
  logic [N_DIV-1:0][RATIO_W-1:0] staged;
  logic [N_DIV-1:0]              div_en;
  logic [N_DIV-1:0]              chg;
  logic [N_DIV-1:0]              parked;
  logic                          go_req;
  logic                          busy;
  logic                          commit;

  cdiv_regs #(
    .N_DIV(N_DIV), .RATIO_W(RATIO_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .busy(busy), .commit(commit), .staged_o(staged), .en_o(div_en),
    .chg_o(chg), .go_req_o(go_req), .rdata(reg_rdata)
  );

  cdiv_go_ctrl #(.N_DIV(N_DIV)) u_go (
    .clk(clk), .rst_n(rst_n), .go_req(go_req), .div_en(div_en),
    .parked(parked), .busy(busy), .commit(commit)
  );

  for (genvar i = 0; i < N_DIV; i++) begin : g_div
    cdiv_counter #(.RATIO_W(RATIO_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en(div_en[i]), .staged(staged[i]),
      .chg(chg[i]), .busy(busy), .commit(commit),
      .pulse_o(clk_en_o[i]), .parked_o(parked[i])
    );
  end

  assert_disabled_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (div_en == '0)) |=> (clk_en_o == '0 || div_en != '0));

  assert_no_pulse_at_commit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (clk_en_o == '0));
endmodule

// File: tb/cdiv_bank_bench.sv
module cdiv_bank_bench;
  localparam int N = 4;
  localparam int AW = 3;
  localparam int DW = 16;
  localparam logic [AW-1:0] A_CMD = 3'd4, A_STAT = 3'd5, A_CHG = 3'd6;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic [N-1:0]  clk_en_o;

  int checks = 0, errors = 0;
  int exp_ratio[N], staged_m[N];
  bit exp_en[N];
  bit drain_flag = 1'b0;
  int last_p = -1, cyc = 0;

  always #2 clk = ~clk;

  cdiv_bank u_cdiv_bank (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .clk_en_o(clk_en_o)
  );

  function automatic bit exp_pulse(int k, int r, bit en);
    return en && ((k % (r + 1)) == r);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle(string req);
    logic [DW-1:0] d;
    for (int t = 0; t < 200; t++) begin
      rd(A_STAT, d);
      if (d[0] == 1'b0) return;
      @(negedge clk);
      #0;
    end
    chk(1'b0, req, 1, 0);
  endtask

  // samples from the first idle cycle onward; status must stay clear (R6)
  task automatic check_window(int len, string req);
    logic [DW-1:0] d;
    for (int k = 0; k < len; k++) begin
      if (k > 0) @(negedge clk);
      rd(A_STAT, d);
      for (int i = 0; i < N; i++)
        chk(clk_en_o[i] == exp_pulse(k, exp_ratio[i], exp_en[i]), req,
            clk_en_o[i], exp_pulse(k, exp_ratio[i], exp_en[i]));
      chk(d[0] == 1'b0, "R6 status stays clear", d[0], 0);
    end
  endtask

  // drain monitor for divider 0 (R10)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      cyc++;
      if (clk_en_o[0]) begin
        if (drain_flag && last_p >= 0)
          chk((cyc - last_p) == exp_ratio[0] + 1, "R10 drain spacing",
              cyc - last_p, exp_ratio[0] + 1);
        last_p = cyc;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    int p1, p2, mask;
    for (int i = 0; i < N; i++) begin exp_ratio[i] = 0; staged_m[i] = 0; exp_en[i] = 0; end
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state (R1, R2)
    chk(clk_en_o == '0, "R2 reset outputs low", clk_en_o, 0);
    rd(3'd0, d); chk(d == '0, "R1 reset divider reg", d, 0);
    rd(A_STAT, d); chk(d == '0, "R4 reset status", d, 0);
    rd(A_CHG, d); chk(d == '0, "R3 reset flags", d, 0);

    // phase A: stage and apply ratio 20 on div0, enable div1 at ratio 0
    wr(3'd0, 16'h8000 | 16'd20);
    rd(3'd0, d); chk(d == 16'h8014, "R1 readback", d, 16'h8014);
    wr(3'd1, 16'h8000);
    rd(A_CHG, d); chk(d[3:0] == 4'b0001, "R3 flag only on change", d[3:0], 1);
    // before GO div0 still runs at ratio 0 (R7)
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); #1;
      chk(clk_en_o[0] == 1'b1, "R7 old period before GO", clk_en_o[0], 1);
    end
    wr(A_CMD, 16'd1);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R4 status set after GO", d[0], 1);
    wait_idle("R4 GO completes");
    exp_ratio[0] = 20; exp_en[0] = 1; exp_en[1] = 1; staged_m[0] = 20;
    check_window(50, "R8 aligned schedule A");
    rd(A_CHG, d); chk(d == '0, "R9 flags cleared", d, 0);

    // phase B: stage ratio 3, verify old period, GO with ignored writes
    wr(3'd0, 16'h8003);
    staged_m[0] = 3;
    p1 = -1; p2 = -1;
    for (int k = 0; k < 50 && p2 < 0; k++) begin
      @(negedge clk); #1;
      if (clk_en_o[0]) begin if (p1 < 0) p1 = k; else p2 = k; end
    end
    chk((p2 - p1) == 21, "R7 staged ratio not yet active", p2 - p1, 21);
    drain_flag = 1'b1;
    wr(A_CMD, 16'd1);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R4 status set", d[0], 1);
    wr(3'd2, 16'h8005);
    rd(3'd2, d); chk(d == '0, "R5 write while busy ignored", d, 0);
    wr(A_CMD, 16'd1);
    wait_idle("R10 drain completes");
    drain_flag = 1'b0;
    exp_ratio[0] = 3;
    check_window(30, "R8 aligned schedule B");
    rd(A_CHG, d); chk(d == '0, "R9 flags cleared B", d, 0);

    // phase C: all disabled, GO busy for one cycle only
    wr(3'd0, 16'h0000);
    wr(3'd1, 16'h0000);
    staged_m[0] = 0; exp_en[0] = 0; exp_en[1] = 0;
    @(negedge clk); #1;
    chk(clk_en_o == '0, "R2 disabled outputs low", clk_en_o, 0);
    wr(A_CMD, 16'd1);
    rd(A_STAT, d); chk(d[0] == 1'b1, "R11 busy one cycle", d[0], 1);
    @(negedge clk);
    rd(A_STAT, d); chk(d[0] == 1'b0, "R11 done next cycle", d[0], 0);
    exp_ratio[0] = 0;

    // phase D: random ratio and enable sets
    for (int it = 0; it < 6; it++) begin
      mask = 0;
      for (int i = 0; i < N; i++) begin
        int r; bit e;
        r = $urandom_range(0, 9);
        e = $urandom_range(0, 3) != 0;
        if (r != staged_m[i]) mask |= (1 << i);
        staged_m[i] = r;
        exp_en[i] = e;
        wr(3'(i), {e, 10'd0, 5'(r)});
      end
      rd(A_CHG, d); chk(d[3:0] == 4'(mask), "R3 random flags", d[3:0], mask);
      wr(A_CMD, 16'd1);
      wait_idle("R4 random GO completes");
      for (int i = 0; i < N; i++) exp_ratio[i] = staged_m[i];
      check_window(40, "R8 random aligned schedule");
      rd(A_CHG, d); chk(d == '0, "R9 random flags cleared", d, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule